// File: doc/BRIEF.md
# Rotate-Right Execution Unit

This unit sits beside the shifter in a 64-bit integer pipeline. It looks at an instruction word in the register-to-register opcode space and decides whether the word is a rotate. Rotates reuse the shift function codes and are told apart by a small marker field. When the unit claims a word, it works out the rotate amount and drives the value to be written to the destination register in the same cycle.

It handles five forms. Four of them are rotates of a 32-bit or a 64-bit value by an immediate amount or by an amount taken from a register. The fifth is a 64-bit immediate form that adds 32 to the encoded amount. The 32-bit forms rotate the low word of the source and sign-extend the result. A registered `done_o` marks each claimed instruction one cycle after it is presented with `valid_i`.

Top module: `rot_unit`

## Requirements
- R1: Immediate 32-bit rotate. It is claimed when bits 31:26 = 000000, bits 5:0 = 000010 and bits 25:21 = 00001. The low 32 bits of the source (bits 20:16 select it) are rotated right by bits 10:6, and the 32-bit result is sign-extended to 64 bits.
- R2: Variable 32-bit rotate. It is claimed when bits 31:26 = 000000, bits 5:0 = 000110 and bits 10:6 = 00001. The amount is bits 4:0 of `rs_val_i`, and all higher bits of `rs_val_i` have no effect on the result.
- R3: Immediate 64-bit rotate. It is claimed when bits 31:26 = 000000, bits 5:0 = 111010 and bits 25:21 = 00001. The full 64-bit source is rotated right by bits 10:6.
- R4: Immediate 64-bit rotate plus 32. It is claimed when bits 31:26 = 000000, bits 5:0 = 111110 and bits 25:21 = 00001. The amount is bits 10:6 plus 32, so an encoded 0 swaps the two halves and an encoded 31 rotates by 63.
- R5: Variable 64-bit rotate. It is claimed when bits 31:26 = 000000, bits 5:0 = 010110 and bits 10:6 = 00001. The amount is bits 5:0 of `rs_val_i`, and the higher bits have no effect.
- R6: A word is not claimed, and `match_o` stays low, in any of these cases: the marker field (bits 25:21 for the immediate forms, bits 10:6 for the variable forms) is not exactly 00001, the top six bits are non-zero, or the function code is none of the five above. Ordinary shifts, whose marker bit 21 or bit 6 is 0, are never claimed.
- R7: A rotate by zero returns the source unchanged. For the 32-bit forms this means the sign-extended low word.
- R8: `dest_o` always equals instruction bits 15:11.
- R9: `done_o` is 0 after reset. In each cycle it is 1 exactly when the previous clock edge saw `valid_i` high with the word claimed.
- R10: While `match_o` is low, `result_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| valid_i | input | 1 | Instruction word is live this cycle |
| instr_i | input | 32 | Instruction word |
| rs_val_i | input | 64 | Value of the amount register (variable forms) |
| rt_val_i | input | 64 | Value of the source register |
| match_o | output | 1 | Word is a rotate this unit executes |
| result_o | output | 64 | Destination value, combinational |
| dest_o | output | 5 | Destination register index |
| done_o | output | 1 | Registered completion, one cycle after a claimed valid word |

## Verification
Two functions can act in the same cycle. The combinational result of a new word appears while `done_o` still reports the word that came before it. The bench provokes this with back-to-back words: a claimed rotate, then an unclaimed shift, then another rotate, each held for one cycle. In every cycle it judges `result_o` against the current word and `done_o` against the word of the previous cycle. The decode boundary is probed with shift encodings that share the rotate function codes and differ only in the marker field.

// File: rtl/rot_pkg.sv
package rot_pkg;
  localparam int unsigned XLEN   = 64;
  localparam int unsigned WLEN   = 32;
  localparam int unsigned AMT_W  = $clog2(XLEN);

  localparam logic [5:0] FN_R32I = 6'b000010;
  localparam logic [5:0] FN_R32V = 6'b000110;
  localparam logic [5:0] FN_R64I = 6'b111010;
  localparam logic [5:0] FN_R64P = 6'b111110;
  localparam logic [5:0] FN_R64V = 6'b010110;
  localparam logic [4:0] MARKER  = 5'b00001;

  typedef enum logic [2:0] {
    OP_NONE,
    OP_R32I,
    OP_R32V,
    OP_R64I,
    OP_R64P,
    OP_R64V
  } rot_op_e;

  typedef struct packed {
    logic [5:0] major;
    logic [4:0] rs;
    logic [4:0] rt;
    logic [4:0] rd;
    logic [4:0] sa;
    logic [5:0] fn;
  } rtype_t;
endpackage

// File: rtl/rot_decode.sv
module rot_decode
  import rot_pkg::*;
(
  input  logic [31:0] instr_i,
  output rot_op_e     op_o,
  output logic        hit_o
);
  rtype_t w;
  assign w = rtype_t'(instr_i);

  always_comb begin
    op_o = OP_NONE;
    if (w.major == 6'b000000) begin
      unique case (w.fn)
        FN_R32I: if (w.rs == MARKER) op_o = OP_R32I;
        FN_R32V: if (w.sa == MARKER) op_o = OP_R32V;
        FN_R64I: if (w.rs == MARKER) op_o = OP_R64I;
        FN_R64P: if (w.rs == MARKER) op_o = OP_R64P;
        FN_R64V: if (w.sa == MARKER) op_o = OP_R64V;
        default: op_o = OP_NONE;
      endcase
    end
  end

  assign hit_o = (op_o != OP_NONE);
endmodule

// File: rtl/rot_amount.sv
module rot_amount
  import rot_pkg::*;
(
  input  rot_op_e          op_i,
  input  logic [4:0]       sa_i,
  input  logic [AMT_W-1:0] rs_lo_i,
  output logic [AMT_W-1:0] amt_o,
  output logic             wide_o
);
  always_comb begin
    amt_o  = '0;
    wide_o = 1'b0;
    unique case (op_i)
      OP_R32I: amt_o = {1'b0, sa_i};
      OP_R32V: amt_o = {1'b0, rs_lo_i[4:0]};
      OP_R64I: begin amt_o = {1'b0, sa_i};  wide_o = 1'b1; end
      OP_R64P: begin amt_o = {1'b1, sa_i};  wide_o = 1'b1; end
      OP_R64V: begin amt_o = rs_lo_i;       wide_o = 1'b1; end
      default: amt_o = '0;
    endcase
  end
endmodule

// File: rtl/rot_barrel.sv
module rot_barrel #(
  parameter int unsigned W  = 64,
  localparam int unsigned SW = $clog2(W)
) (
  input  logic [W-1:0]  data_i,
  input  logic [SW-1:0] amt_i,
  output logic [W-1:0]  data_o
);
  logic [W-1:0] stage [SW+1];
  assign stage[0] = data_i;

  for (genvar k = 0; k < SW; k++) begin : g_stage
    localparam int unsigned S = 1 << k;
    assign stage[k+1] = amt_i[k] ? {stage[k][S-1:0], stage[k][W-1:S]} : stage[k];
  end

  assign data_o = stage[SW];
endmodule

// File: rtl/rot_unit.sv
module rot_unit
  import rot_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        valid_i,
  input  logic [31:0] instr_i,
  input  logic [63:0] rs_val_i,
  input  logic [63:0] rt_val_i,
  output logic        match_o,
  output logic [63:0] result_o,
  output logic [4:0]  dest_o,
  output logic        done_o
);
  rot_op_e          op;
  logic             hit;
  logic [AMT_W-1:0] amt;
  logic             wide;
  logic [XLEN-1:0]  r_wide;
  logic [WLEN-1:0]  r_narrow;
  logic             unused_rs_hi;

  assign unused_rs_hi = ^rs_val_i[63:AMT_W];

  rot_decode i_dec (
    .instr_i (instr_i),
    .op_o    (op),
    .hit_o   (hit)
  );

  rot_amount i_amt (
    .op_i    (op),
    .sa_i    (instr_i[10:6]),
    .rs_lo_i (rs_val_i[AMT_W-1:0]),
    .amt_o   (amt),
    .wide_o  (wide)
  );

  rot_barrel #(.W(XLEN)) i_rot_wide (
    .data_i (rt_val_i),
    .amt_i  (amt),
    .data_o (r_wide)
  );

  rot_barrel #(.W(WLEN)) i_rot_narrow (
    .data_i (rt_val_i[WLEN-1:0]),
    .amt_i  (amt[$clog2(WLEN)-1:0]),
    .data_o (r_narrow)
  );

  always_comb begin
    if (!hit)      result_o = '0;
    else if (wide) result_o = r_wide;
    else           result_o = {{(XLEN-WLEN){r_narrow[WLEN-1]}}, r_narrow};
  end

  assign match_o = hit;
  assign dest_o  = instr_i[15:11];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) done_o <= 1'b0;
    else         done_o <= valid_i & hit;
  end
endmodule

// File: rtl/rot_unit_chk.sv
module rot_unit_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        valid_i,
  input logic [31:0] instr_i,
  input logic [63:0] rt_val_i,
  input logic        match_o,
  input logic [63:0] result_o,
  input logic        done_o
);
  a_r9_done_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && match_o) |=> done_o);

  a_r9_no_spurious_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!(valid_i && match_o)) |=> !done_o);

  a_r6_marker_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    match_o |-> (instr_i[21] || instr_i[6]));

  a_r6_major_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    match_o |-> (instr_i[31:26] == 6'b000000));

  a_r10_idle_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !match_o |-> (result_o == 64'd0));

  a_r1_sign_ext: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (match_o && (instr_i[5:0] == 6'b000010 || instr_i[5:0] == 6'b000110))
      |-> (result_o[63:32] == {32{result_o[31]}}));

  a_r4_half_swap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (match_o && instr_i[5:0] == 6'b111110 && instr_i[10:6] == 5'd0)
      |-> (result_o == {rt_val_i[31:0], rt_val_i[63:32]}));
endmodule

bind rot_unit rot_unit_chk i_rot_unit_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .valid_i  (valid_i),
  .instr_i  (instr_i),
  .rt_val_i (rt_val_i),
  .match_o  (match_o),
  .result_o (result_o),
  .done_o   (done_o)
);

// File: tb/test_rot_unit.sv
`timescale 1ns/1ps
module test_rot_unit;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [31:0] instr_i = '0;
  logic [63:0] rs_val_i = '0;
  logic [63:0] rt_val_i = '0;
  logic        match_o;
  logic [63:0] result_o;
  logic [4:0]  dest_o;
  logic        done_o;

  int checks = 0;
  int errors = 0;

  always #10 clk_i = ~clk_i;

  rot_unit i_rot_unit (.*);

  function automatic logic [31:0] mk(input logic [4:0] rs, input logic [4:0] rt,
                                     input logic [4:0] rd, input logic [4:0] sa,
                                     input logic [5:0] fn);
    return {6'b000000, rs, rt, rd, sa, fn};
  endfunction

  function automatic logic [63:0] ref_rot(input logic [63:0] v, input int amt, input bit w64);
    logic [63:0] o = '0;
    logic [31:0] t = '0;
    if (w64) begin
      for (int i = 0; i < 64; i++) o[i] = v[(i + amt) % 64];
    end else begin
      for (int i = 0; i < 32; i++) t[i] = v[(i + amt) % 32];
      o = {{32{t[31]}}, t};
    end
    return o;
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Drive one word, check comb outputs, then done_o after the edge.
  task automatic run(input string req, input logic [31:0] w, input logic [63:0] rs,
                     input logic [63:0] rt, input logic exp_m, input logic [63:0] exp_r);
    @(negedge clk_i);
    valid_i = 1'b1; instr_i = w; rs_val_i = rs; rt_val_i = rt;
    #2;
    chk({req, " match"}, {63'd0, match_o}, {63'd0, exp_m});
    chk({req, " result"}, result_o, exp_r);
    chk({"R8 dest"}, {59'd0, dest_o}, {59'd0, w[15:11]});
    @(posedge clk_i); #2;
    chk({"R9 done after ", req}, {63'd0, done_o}, {63'd0, exp_m});
  endtask

  localparam logic [63:0] PAT = 64'hF00D_1234_8765_4321;

  task automatic t_reset();
    #3;
    chk("R9 reset done", {63'd0, done_o}, 64'd0);
    chk("R10 reset result", result_o, 64'd0);
    @(negedge clk_i); rst_ni = 1'b1;
  endtask

  task automatic t_r32_imm();
    run("R1 amt1", mk(5'd1, 5'd3, 5'd7, 5'd1, 6'b000010), '0,
        64'hAAAA_0000_0000_0003, 1'b1, 64'hFFFF_FFFF_8000_0001);
    for (int a = 5; a < 32; a += 13)
      run("R1 sweep", mk(5'd1, 5'd2, 5'd9, 5'(a), 6'b000010), '0, PAT, 1'b1, ref_rot(PAT, a, 0));
    run("R1 amt31", mk(5'd1, 5'd2, 5'd9, 5'd31, 6'b000010), '0, PAT, 1'b1, ref_rot(PAT, 31, 0));
  endtask

  task automatic t_r32_var();
    run("R2 hi bits ignored", mk(5'd4, 5'd2, 5'd1, 5'd1, 6'b000110),
        64'hFFFF_FFFF_FFFF_FFE3, PAT, 1'b1, ref_rot(PAT, 3, 0));
    run("R2 amt17", mk(5'd4, 5'd2, 5'd1, 5'd1, 6'b000110), 64'd17, PAT, 1'b1, ref_rot(PAT, 17, 0));
  endtask

  task automatic t_r64_imm();
    run("R3 amt4", mk(5'd1, 5'd6, 5'd30, 5'd4, 6'b111010), '0, PAT, 1'b1, ref_rot(PAT, 4, 1));
    run("R3 amt31", mk(5'd1, 5'd6, 5'd30, 5'd31, 6'b111010), '0, PAT, 1'b1, ref_rot(PAT, 31, 1));
  endtask

  task automatic t_r64_p32();
    run("R4 sa0 swap", mk(5'd1, 5'd6, 5'd2, 5'd0, 6'b111110), '0, PAT, 1'b1,
        {PAT[31:0], PAT[63:32]});
    run("R4 sa31 is 63", mk(5'd1, 5'd6, 5'd2, 5'd31, 6'b111110), '0, PAT, 1'b1, ref_rot(PAT, 63, 1));
  endtask

  task automatic t_r64_var();
    run("R5 amt63 hi ignored", mk(5'd8, 5'd6, 5'd2, 5'd1, 6'b010110),
        64'h1234_0000_0000_00FF, PAT, 1'b1, ref_rot(PAT, 63, 1));
    run("R5 amt40", mk(5'd8, 5'd6, 5'd2, 5'd1, 6'b010110), 64'd40, PAT, 1'b1, ref_rot(PAT, 40, 1));
  endtask

  task automatic t_zero();
    run("R7 r32 zero", mk(5'd1, 5'd1, 5'd1, 5'd0, 6'b000010), '0,
        64'h0123_4567_89AB_CDEF, 1'b1, 64'hFFFF_FFFF_89AB_CDEF);
    run("R7 r64 zero", mk(5'd1, 5'd1, 5'd1, 5'd0, 6'b111010), '0, PAT, 1'b1, PAT);
    run("R7 r64v zero", mk(5'd3, 5'd1, 5'd1, 5'd1, 6'b010110), 64'hC0, PAT, 1'b1, PAT);
  endtask

  task automatic t_no_claim();
    run("R6 plain srl", mk(5'd0, 5'd2, 5'd3, 5'd4, 6'b000010), '0, PAT, 1'b0, 64'd0);
    run("R6 plain srlv", mk(5'd5, 5'd2, 5'd3, 5'd0, 6'b000110), 64'd3, PAT, 1'b0, 64'd0);
    run("R6 plain dsrl", mk(5'd0, 5'd2, 5'd3, 5'd4, 6'b111010), '0, PAT, 1'b0, 64'd0);
    run("R6 marker 00011", mk(5'd3, 5'd2, 5'd3, 5'd4, 6'b111110), '0, PAT, 1'b0, 64'd0);
    run("R6 varmarker 00011", mk(5'd5, 5'd2, 5'd3, 5'd3, 6'b010110), 64'd3, PAT, 1'b0, 64'd0);
    run("R6 major nonzero", {6'b000001, 5'd1, 5'd2, 5'd3, 5'd4, 6'b000010}, '0, PAT, 1'b0, 64'd0);
    run("R10 other fn", mk(5'd1, 5'd2, 5'd3, 5'd4, 6'b100000), '0, PAT, 1'b0, 64'd0);
  endtask

  task automatic t_overlap();
    // rotate, non-rotate, idle rotate: done must track the prior cycle
    run("R9 b2b rot", mk(5'd1, 5'd2, 5'd3, 5'd8, 6'b111010), '0, PAT, 1'b1, ref_rot(PAT, 8, 1));
    run("R9 b2b shift", mk(5'd0, 5'd2, 5'd3, 5'd8, 6'b111010), '0, PAT, 1'b0, 64'd0);
    @(negedge clk_i);
    valid_i = 1'b0; instr_i = mk(5'd1, 5'd2, 5'd3, 5'd8, 6'b111010);
    #2;
    chk("R3 result without valid", result_o, ref_rot(PAT, 8, 1));
    @(posedge clk_i); #2;
    chk("R9 no done without valid", {63'd0, done_o}, 64'd0);
  endtask

  initial begin
    t_reset();
    t_r32_imm();
    t_r32_var();
    t_r64_imm();
    t_r64_p32();
    t_r64_var();
    t_zero();
    t_no_claim();
    t_overlap();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(20 * 100000);
    errors++;
    checks++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule